// File: doc/BRIEF.md
# Low-Resolution Playfield Pixel Generator

This block turns a 20-bit playfield pattern into a colour value for every colour clock of a scanline. A host loads the pattern through three registers: one 4-bit register and two 8-bit registers. It also loads a playfield colour, a background colour, a blanking control and a mode control, all through a single address/data write port. A horizontal position input gives the colour clock being drawn. The visible part of the line is 160 clocks wide and is split into 40 coarse pixels, each 4 clocks wide. The 20 stored bits fill the left half of the line. The right half shows them again, either repeated in the same order or mirrored.

Every register keeps its value until the host rewrites it, so the same picture is drawn on every line and every frame with no further traffic. A write lands before the next colour clock. This lets a host change the pattern partway through a line and draw a right half that differs from the left. The output is registered. It is black during horizontal blank and whenever the blanking bit is set.

Top module: `pf_pixel_gen`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads as zero and the output is 0x00. With only the background colour written afterwards, every visible pixel shows that colour.
- R2: A write with wr_en high stores wr_data as follows. Address 0 stores the pattern nibble, which is wr_data[7:4]; wr_data[3:0] is discarded. Address 1 stores the first pattern byte. Address 2 stores the second pattern byte. Address 3 stores the playfield colour. Address 4 stores the background colour. Address 5 stores the blank control, whose bit 1 is the blank flag. Address 6 stores the mode, whose bit 0 selects mirror. A write to address 7 changes nothing.
- R3: pix_colour is registered. The value present after a rising edge belongs to the hpos sampled at that edge. It is the playfield colour when the selected pattern bit is 1 and the background colour when that bit is 0.
- R4: At a visible position h (0 to 159), the coarse pixel is p = h/4. All four clocks of a coarse pixel show the same value.
- R5: Pattern index i is read from the registers as follows. For i = 0..3 it is nibble bit i, which is wr_data bit 4+i of the address-0 write. For i = 4..11 it is first-byte bit 11-i, so the most significant bit comes first. For i = 12..19 it is second-byte bit i-12, so the least significant bit comes first.
- R6: Coarse pixels 0 to 19 show index i = p. When mirror is 0, coarse pixels 20 to 39 show index i = p-20.
- R7: When mirror is 1, coarse pixels 20 to 39 show index i = 39-p. The left half does not change.
- R8: While the blank flag (blank control bit 1) is set, the output is 0x00. The other bits of the blank control have no effect.
- R9: At positions 160 and above, the output is 0x00.
- R10: A write at a rising edge does not affect the pixel captured at that same edge. It does affect the pixel captured at the next edge, so a pattern can be changed partway through a line.
- R11: Register contents stay unchanged across any number of cycles that have no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| hpos | input | 8 | Horizontal colour-clock position |
| pix_colour | output | 8 | Colour for the clock captured at the last edge |

## Verification
A wrong bit in the stored pattern, or a wrong index decode, shows up in one clock: a colour swaps between playfield and background, and only within the four-clock span of one coarse pixel. That is why the bench sweeps whole lines in both repeat and mirror mode against an independent position model. A stuck blank flag or a stale colour register makes every visible pixel wrong starting on the clock after the write. A write that lands one cycle late or early is only visible right at the mid-line change, so that exact edge is checked on its own.

// File: rtl/pf_pkg.sv
package pf_pkg;
   // register select width and decode values
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_NIB    = 3'd0;
   localparam logic [ADDR_W-1:0] A_BYTE1  = 3'd1;
   localparam logic [ADDR_W-1:0] A_BYTE2  = 3'd2;
   localparam logic [ADDR_W-1:0] A_PFCOL  = 3'd3;
   localparam logic [ADDR_W-1:0] A_BGCOL  = 3'd4;
   localparam logic [ADDR_W-1:0] A_BLANK  = 3'd5;
   localparam logic [ADDR_W-1:0] A_MODE   = 3'd6;
   // control bit positions
   localparam int BLANK_BIT  = 1;
   localparam int MIRROR_BIT = 0;
endpackage

// File: rtl/pf_regfile.sv
module pf_regfile
   import pf_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int NIB_W   = 4,
   parameter int COLOR_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [BYTE_W-1:0]    wr_data,
   output logic [NIB_W-1:0]     nib_q,
   output logic [BYTE_W-1:0]    byte1_q,
   output logic [BYTE_W-1:0]    byte2_q,
   output logic [COLOR_W-1:0]   pf_col_q,
   output logic [COLOR_W-1:0]   bg_col_q,
   output logic                 blank_q,
   output logic                 mirror_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nib_q    <= '0;
         byte1_q  <= '0;
         byte2_q  <= '0;
         pf_col_q <= '0;
         bg_col_q <= '0;
         blank_q  <= 1'b0;
         mirror_q <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            A_NIB:   nib_q    <= wr_data[BYTE_W-1 -: NIB_W];
            A_BYTE1: byte1_q  <= wr_data;
            A_BYTE2: byte2_q  <= wr_data;
            A_PFCOL: pf_col_q <= wr_data[COLOR_W-1:0];
            A_BGCOL: bg_col_q <= wr_data[COLOR_W-1:0];
            A_BLANK: blank_q  <= wr_data[BLANK_BIT];
            A_MODE:  mirror_q <= wr_data[MIRROR_BIT];
            default: ;
         endcase
      end
   end

   // R10: a colour write is visible right after its edge
   p_pfcol_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_PFCOL) |=> (pf_col_q == $past(wr_data[COLOR_W-1:0])));

   // R11: with no write, every stored value holds
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({nib_q, byte1_q, byte2_q, pf_col_q, bg_col_q, blank_q, mirror_q}));

   // R2: the unused address leaves the pattern untouched
   p_unused_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd7) |=> $stable({nib_q, byte1_q, byte2_q}));

endmodule

// File: rtl/pf_pos_decode.sv
module pf_pos_decode #(
   parameter int HPOS_W    = 8,
   parameter int PIX_CLKS  = 4,
   parameter int PF_BITS   = 20,
   parameter bit MIRROR_EN = 1'b1,
   localparam int PIX_SHIFT = $clog2(PIX_CLKS),
   localparam int PN_W      = HPOS_W - PIX_SHIFT,
   localparam int LINE_W    = 2 * PF_BITS * PIX_CLKS
) (
   input  logic [HPOS_W-1:0] hpos,
   input  logic              mirror,
   output logic              visible,
   output logic [PN_W-1:0]   bit_idx
);

   logic [PN_W-1:0] pix_num;
   logic            right_half;

   assign visible    = (hpos < HPOS_W'(LINE_W));
   assign pix_num    = hpos[HPOS_W-1:PIX_SHIFT];
   assign right_half = (pix_num >= PN_W'(PF_BITS));

   generate
      if (MIRROR_EN) begin : g_mirror
         always_comb begin
            if (!right_half)
               bit_idx = pix_num;
            else if (mirror)
               bit_idx = PN_W'(2 * PF_BITS - 1) - pix_num;
            else
               bit_idx = pix_num - PN_W'(PF_BITS);
         end
      end else begin : g_repeat
         logic pf_unused_mirror;
         assign pf_unused_mirror = mirror;
         assign bit_idx = right_half ? (pix_num - PN_W'(PF_BITS)) : pix_num;
      end
   endgenerate

endmodule

// File: rtl/pf_bit_select.sv
module pf_bit_select #(
   parameter int NIB_W  = 4,
   parameter int BYTE_W = 8,
   parameter int PN_W   = 6,
   localparam int PF_BITS = NIB_W + 2 * BYTE_W
) (
   input  logic [NIB_W-1:0]  nib,
   input  logic [BYTE_W-1:0] byte1,
   input  logic [BYTE_W-1:0] byte2,
   input  logic [PN_W-1:0]   bit_idx,
   output logic              pf_bit
);

   logic [PF_BITS-1:0] pattern;

   // R5: scan order -- nibble LSB first, byte1 MSB first, byte2 LSB first
   generate
      for (genvar n = 0; n < NIB_W; n++) begin : g_nib
         assign pattern[n] = nib[n];
      end
      for (genvar b = 0; b < BYTE_W; b++) begin : g_bytes
         assign pattern[NIB_W + b]          = byte1[BYTE_W-1-b];
         assign pattern[NIB_W + BYTE_W + b] = byte2[b];
      end
   endgenerate

   always_comb begin
      pf_bit = 1'b0;
      for (int i = 0; i < PF_BITS; i++) begin
         if (bit_idx == PN_W'(i)) pf_bit = pattern[i];
      end
   end

endmodule

// File: rtl/pf_pixel_gen.sv
module pf_pixel_gen
   import pf_pkg::*;
#(
   parameter int COLOR_W   = 8,
   parameter int HPOS_W    = 8,
   parameter int PIX_CLKS  = 4,
   parameter int NIB_W     = 4,
   parameter int BYTE_W    = 8,
   parameter bit MIRROR_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic [HPOS_W-1:0]   hpos,
   output logic [COLOR_W-1:0]  pix_colour
);

   localparam int PF_BITS   = NIB_W + 2 * BYTE_W;
   localparam int LINE_W    = 2 * PF_BITS * PIX_CLKS;
   localparam int PIX_SHIFT = $clog2(PIX_CLKS);
   localparam int PN_W      = HPOS_W - PIX_SHIFT;

   initial begin
      assert ((1 << PIX_SHIFT) == PIX_CLKS) else $fatal(1, "PIX_CLKS must be a power of two");
      assert (LINE_W < (1 << HPOS_W)) else $fatal(1, "HPOS_W too narrow for the line");
      assert (COLOR_W <= BYTE_W) else $fatal(1, "colour wider than write data");
      assert (NIB_W <= BYTE_W) else $fatal(1, "nibble wider than write data");
   end

   logic [NIB_W-1:0]   nib_q;
   logic [BYTE_W-1:0]  byte1_q, byte2_q;
   logic [COLOR_W-1:0] pf_col_q, bg_col_q;
   logic               blank_q, mirror_q;
   logic               visible, pf_bit;
   logic [PN_W-1:0]    bit_idx;

   pf_regfile #(.BYTE_W(BYTE_W), .NIB_W(NIB_W), .COLOR_W(COLOR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .nib_q(nib_q), .byte1_q(byte1_q), .byte2_q(byte2_q),
      .pf_col_q(pf_col_q), .bg_col_q(bg_col_q), .blank_q(blank_q), .mirror_q(mirror_q));

   pf_pos_decode #(.HPOS_W(HPOS_W), .PIX_CLKS(PIX_CLKS), .PF_BITS(PF_BITS),
                   .MIRROR_EN(MIRROR_EN)) u_pos (
      .hpos(hpos), .mirror(mirror_q), .visible(visible), .bit_idx(bit_idx));

   pf_bit_select #(.NIB_W(NIB_W), .BYTE_W(BYTE_W), .PN_W(PN_W)) u_sel (
      .nib(nib_q), .byte1(byte1_q), .byte2(byte2_q), .bit_idx(bit_idx), .pf_bit(pf_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pix_colour <= '0;
      else if (blank_q || !visible)
         pix_colour <= '0;
      else
         pix_colour <= pf_bit ? pf_col_q : bg_col_q;
   end

   // R8: blank flag forces black on the following pixel
   p_blank_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
      blank_q |=> (pix_colour == '0));

   // R9: positions beyond the visible line are black
   p_hblank_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hpos >= HPOS_W'(LINE_W)) |=> (pix_colour == '0));

   // R3: output is only ever black, playfield colour or background colour
   p_legal_colour_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pix_colour == '0 || pix_colour == $past(pf_col_q)
                || pix_colour == $past(bg_col_q)));

endmodule

// File: tb/pf_pixel_gen_test.sv
module pf_pixel_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 19;
   // {hpos, expected colour} with nib=0x5, byte1=0xC1, byte2=0x81, pf=0x45, bg=0x0E, repeat mode
   localparam logic [15:0] VEC [NVEC] = '{
      {8'd0,   8'h45}, {8'd3,   8'h45}, {8'd4,   8'h0E}, {8'd8,   8'h45},
      {8'd12,  8'h0E}, {8'd16,  8'h45}, {8'd24,  8'h0E}, {8'd44,  8'h45},
      {8'd48,  8'h45}, {8'd52,  8'h0E}, {8'd76,  8'h45}, {8'd79,  8'h45},
      {8'd80,  8'h45}, {8'd84,  8'h0E}, {8'd152, 8'h0E}, {8'd156, 8'h45},
      {8'd160, 8'h00}, {8'd200, 8'h00}, {8'd255, 8'h00}};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] hpos = '0;
   logic [7:0] pix_colour;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench shadow of the host-visible state
   logic [3:0] s_nib = '0;
   logic [7:0] s_b1 = '0, s_b2 = '0, s_pf = '0, s_bg = '0;
   logic       s_blank = 1'b0, s_mirror = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pf_pixel_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .hpos(hpos), .pix_colour(pix_colour));

   function automatic logic [7:0] ref_pix(int h);
      int p, i;
      logic b;
      if (s_blank || h >= 160) return 8'h00;
      p = h / 4;
      if (p < 20) i = p;
      else if (s_mirror) i = 39 - p;
      else i = p - 20;
      if (i < 4) b = s_nib[i];
      else if (i < 12) b = s_b1[11 - i];
      else b = s_b2[i - 12];
      return b ? s_pf : s_bg;
   endfunction

   task automatic check(string req, logic [7:0] exp);
      n_tests++;
      if (pix_colour !== exp) begin
         n_fail++;
         $display("FAIL %s hpos=%0d actual=%02h expected=%02h", req, hpos, pix_colour, exp);
      end
   endtask

   task automatic step(logic [7:0] h);
      hpos = h;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d; hpos = 8'd255;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         3'd0: s_nib = d[7:4];
         3'd1: s_b1 = d;
         3'd2: s_b2 = d;
         3'd3: s_pf = d;
         3'd4: s_bg = d;
         3'd5: s_blank = d[1];
         3'd6: s_mirror = d[0];
         default: ;
      endcase
   endtask

   task automatic sweep(string req);
      for (int h = 0; h < 176; h++) begin
         step(8'(h));
         check(req, ref_pix(h));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      @(negedge clk); @(negedge clk);
      check("R1 during reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      step(8'd0);   check("R1 after reset", 8'h00);
      wr(3'd4, 8'h22);
      step(8'd0);   check("R1 zero pattern shows bg", 8'h22);
      step(8'd156); check("R1 zero pattern shows bg", 8'h22);

      // R2/R5 configure, then table walk (R4 R5 R6 R9)
      wr(3'd0, 8'h50); wr(3'd1, 8'hC1); wr(3'd2, 8'h81);
      wr(3'd3, 8'h45); wr(3'd4, 8'h0E);
      for (int v = 0; v < NVEC; v++) begin
         step(VEC[v][15:8]);
         check("R4/R5/R6/R9 table", VEC[v][7:0]);
      end
      sweep("R6 repeat sweep");

      // R7 mirror
      wr(3'd6, 8'h01);
      step(8'd80);  check("R7 mirror p20", 8'h45);
      step(8'd84);  check("R7 mirror p21", 8'h0E);
      step(8'd152); check("R7 mirror p38", 8'h0E);
      step(8'd156); check("R7 mirror p39", 8'h45);
      step(8'd4);   check("R7 left unchanged", 8'h0E);
      sweep("R7 mirror sweep");
      wr(3'd6, 8'h00);

      // R10 mid-line write: same-edge pixel uses old pattern, next uses new
      wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h00; hpos = 8'd48;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; s_b2 = 8'h00;
      check("R10 old value at write edge", 8'h45);
      step(8'd48);  check("R10 new value next clock", 8'h0E);
      step(8'd8);   check("R10 left half untouched", 8'h45);
      wr(3'd2, 8'h81);

      // R8 blank
      wr(3'd5, 8'h02);
      step(8'd0);   check("R8 blank set", 8'h00);
      step(8'd4);   check("R8 blank set bg", 8'h00);
      wr(3'd5, 8'hFD);
      step(8'd0);   check("R8 other bits no effect", 8'h45);

      // R2 low nibble discarded
      wr(3'd0, 8'h0F);
      step(8'd0);   check("R2 nibble low bits ignored", 8'h0E);
      step(8'd8);   check("R2 nibble low bits ignored", 8'h0E);
      wr(3'd0, 8'h50);

      // R2 address 7 changes nothing
      wr(3'd7, 8'hFF);
      sweep("R2 addr7 no effect");

      // R11 persistence
      repeat (50) @(negedge clk);
      step(8'd44);  check("R11 persist", 8'h45);
      step(8'd52);  check("R11 persist", 8'h0E);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule